// File: doc/BRIEF.md
# Exception Entry State-Save Unit

This unit performs the architectural register update that happens at the moment a processor core accepts an exception. The core presents a single-cycle accept strobe together with a two-bit vector selector and the return address. On that clock edge the unit captures the return address into the first save/restore register, captures the low half of the machine state register into the second save/restore register, and rewrites the machine state register so that the handler starts in a known mode. One cycle later it presents the handler fetch address with a valid flag.

The handler fetch address is a 20-bit vector offset added to one of two base addresses. The interrupt-prefix bit of the machine state register picks the base. Because that bit survives the rewrite, the base matches the mode the handler runs in. A software write port can load the machine state register when no exception is being accepted. Choosing which exception wins and returning from the handler are handled elsewhere.

A small state machine tracks the dispatch. It has two states. ST_IDLE means no handler address is pending. ST_DISPATCH means the handler address output is valid. The transition IDLE->DISPATCH fires on an accept strobe. DISPATCH->DISPATCH fires on a back-to-back strobe. DISPATCH->IDLE and IDLE->IDLE fire when there is no strobe.

Top module: `exc_entry_save`

## Requirements
- R1: After reset, the machine state register, both save/restore registers and the handler address are all zero, and handler_valid is low.
- R2: On the clock edge where take_i is high, srr0_o loads ret_addr_i.
- R3: On that edge, srr1_o bits 0..15 (vector [31:16]) are cleared, and srr1_o bits 16..31 (vector [15:0]) take the pre-entry machine state register bits 16..31 (vector [15:0]). Numbering is big-endian, so architectural bit n is vector index 31-n.
- R4: On entry, the following architectural machine-state bits are cleared: wake-power 13, alternate-GPR 14, ext-enable 16, user-mode 17, FP-available 18, FP-mode-0 20, single-step 21, branch-trace 22, FP-mode-1 23, instr-translate 26, data-translate 27, recoverable 30.
- R5: On entry, interrupt-endian (bit 15), prefix (bit 25), machine-check-enable (bit 19) and every bit not named in R4 keep their values. The exception is little-endian (bit 31), which is loaded with the pre-entry value of bit 15.
- R6: The handler address equals the base plus the vector offset. The base is 0x00000000 when bit 25 is 0 and 0xFFF00000 when bit 25 is 1.
- R7: vec_code_i selects the offset as follows: 0 gives 0x00300 (data storage), 1 gives 0x01200 (data TLB miss on store), 2 gives 0x01300 (address breakpoint), 3 gives 0x01400 (system management).
- R8: handler_valid_o is high in exactly the cycle following each edge where take_i was high, and low otherwise.
- R9: With take_i and msr_we_i both low, the machine state register and both save/restore registers hold their values.
- R10: msr_we_i loads msr_wdata_i into the machine state register on the next edge. When take_i is high in the same cycle, the write is discarded and the entry rewrite applies instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception accept strobe, one cycle |
| vec_code_i | input | 2 | Vector selector (encoding per R7) |
| ret_addr_i | input | 32 | Return address to be saved |
| msr_we_i | input | 1 | Software write enable for the machine state register |
| msr_wdata_i | input | 32 | Software write data |
| msr_o | output | 32 | Machine state register |
| srr0_o | output | 32 | Save/restore register 0 |
| srr1_o | output | 32 | Save/restore register 1 |
| handler_addr_o | output | 32 | Handler fetch address |
| handler_valid_o | output | 1 | Handler address valid |

## Verification
Every result of an accepted exception is due exactly one clock edge after the strobe. This covers both save/restore registers, the rewritten machine state register, the handler address and its valid flag. The bench drives the strobe on a falling edge and samples all outputs on the following falling edge. It then samples once more a cycle later to confirm that the valid flag drops and the registers hold. Software writes follow the same one-edge latency, so each preloaded machine state is read back before the strobe that consumes it.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int XLEN = 32;
    localparam int HALF = XLEN / 2;

    // architectural (big-endian) bit numbers of the machine state register
    localparam int A_POW  = 13;
    localparam int A_TGPR = 14;
    localparam int A_ILE  = 15;
    localparam int A_EE   = 16;
    localparam int A_PR   = 17;
    localparam int A_FP   = 18;
    localparam int A_ME   = 19;
    localparam int A_FE0  = 20;
    localparam int A_SE   = 21;
    localparam int A_BE   = 22;
    localparam int A_FE1  = 23;
    localparam int A_IP   = 25;
    localparam int A_IR   = 26;
    localparam int A_DR   = 27;
    localparam int A_RI   = 30;
    localparam int A_LE   = 31;

    // vector index of an architectural bit number
    function automatic int vidx(input int arch_bit);
        return XLEN - 1 - arch_bit;
    endfunction

    function automatic logic [XLEN-1:0] onehot_at(input int arch_bit);
        logic [XLEN-1:0] v;
        v = '0;
        v[vidx(arch_bit)] = 1'b1;
        return v;
    endfunction

    localparam logic [XLEN-1:0] MSR_CLEAR_MASK =
        onehot_at(A_POW) | onehot_at(A_TGPR) | onehot_at(A_EE)  |
        onehot_at(A_PR)  | onehot_at(A_FP)   | onehot_at(A_FE0) |
        onehot_at(A_SE)  | onehot_at(A_BE)   | onehot_at(A_FE1) |
        onehot_at(A_IR)  | onehot_at(A_DR)   | onehot_at(A_RI);

    typedef enum logic [1:0] {
        VEC_DSI     = 2'd0,
        VEC_DTLB_ST = 2'd1,
        VEC_IABP    = 2'd2,
        VEC_SMI     = 2'd3
    } vec_code_e;

    typedef enum logic {
        ST_IDLE     = 1'b0,
        ST_DISPATCH = 1'b1
    } entry_state_e;

endpackage

// File: rtl/exc_vector_map.sv
module exc_vector_map
    import exc_entry_pkg::*;
#(
    parameter int OFF_W = 20
) (
    input  logic [1:0]       code_i,
    output logic [OFF_W-1:0] offset_o
);

    vec_code_e code;
    assign code = vec_code_e'(code_i);

    always_comb begin
        unique case (code)
            VEC_DSI:     offset_o = OFF_W'(20'h00300);
            VEC_DTLB_ST: offset_o = OFF_W'(20'h01200);
            VEC_IABP:    offset_o = OFF_W'(20'h01300);
            VEC_SMI:     offset_o = OFF_W'(20'h01400);
            default:     offset_o = '0;
        endcase
    end

    always_comb begin
        assert (offset_o[7:0] == 8'h00)
            else $error("p_offset_aligned_r7: offset not 256-byte aligned");
    end

endmodule

// File: rtl/exc_base_sel.sv
module exc_base_sel
    import exc_entry_pkg::*;
#(
    parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFF0_0000,
    parameter int              OFF_W     = 20
) (
    input  logic              prefix_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [XLEN-1:0]   addr_o
);

    localparam int PAD_W = XLEN - OFF_W;

    logic [XLEN-1:0] base;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_o = base + {{PAD_W{1'b0}}, offset_i};
        end else begin : g_nopad
            assign addr_o = base + offset_i[XLEN-1:0];
        end
    endgenerate

    assign base = prefix_i ? HIGH_BASE : '0;

endmodule

// File: rtl/exc_msr_rewrite.sv
module exc_msr_rewrite
    import exc_entry_pkg::*;
(
    input  logic [XLEN-1:0] msr_i,
    output logic [XLEN-1:0] msr_entry_o,
    output logic [XLEN-1:0] srr1_o
);

    always_comb begin
        msr_entry_o                = msr_i & ~MSR_CLEAR_MASK;
        msr_entry_o[vidx(A_LE)]    = msr_i[vidx(A_ILE)];
    end

    always_comb begin
        srr1_o = {{HALF{1'b0}}, msr_i[HALF-1:0]};
    end

    always_comb begin
        assert (msr_entry_o[vidx(A_IP)] == msr_i[vidx(A_IP)])
            else $error("p_ip_kept_r5: prefix bit altered by rewrite");
        assert (msr_entry_o[vidx(A_ME)] == msr_i[vidx(A_ME)])
            else $error("p_me_kept_r5: machine-check enable altered by rewrite");
    end

endmodule

// File: rtl/exc_entry_save.sv
module exc_entry_save
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] HIGH_BASE = 32'hFFF0_0000,
    parameter int          OFF_W     = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        take_i,
    input  logic [1:0]  vec_code_i,
    input  logic [31:0] ret_addr_i,
    input  logic        msr_we_i,
    input  logic [31:0] msr_wdata_i,
    output logic [31:0] msr_o,
    output logic [31:0] srr0_o,
    output logic [31:0] srr1_o,
    output logic [31:0] handler_addr_o,
    output logic        handler_valid_o
);

    entry_state_e state_q, state_d;

    logic [XLEN-1:0]  msr_q, srr0_q, srr1_q, haddr_q;
    logic [XLEN-1:0]  msr_entry, srr1_entry, haddr_next;
    logic [OFF_W-1:0] offset;

    exc_vector_map #(.OFF_W(OFF_W)) u_vmap (
        .code_i   (vec_code_i),
        .offset_o (offset)
    );

    exc_base_sel #(.HIGH_BASE(HIGH_BASE), .OFF_W(OFF_W)) u_base (
        .prefix_i (msr_q[vidx(A_IP)]),
        .offset_i (offset),
        .addr_o   (haddr_next)
    );

    exc_msr_rewrite u_rw (
        .msr_i       (msr_q),
        .msr_entry_o (msr_entry),
        .srr1_o      (srr1_entry)
    );

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:     state_d = take_i ? ST_DISPATCH : ST_IDLE;
            ST_DISPATCH: state_d = take_i ? ST_DISPATCH : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state and architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            msr_q   <= '0;
            srr0_q  <= '0;
            srr1_q  <= '0;
            haddr_q <= '0;
        end else begin
            state_q <= state_d;
            if (take_i) begin
                msr_q   <= msr_entry;
                srr0_q  <= ret_addr_i;
                srr1_q  <= srr1_entry;
                haddr_q <= haddr_next;
            end else if (msr_we_i) begin
                msr_q   <= msr_wdata_i;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:     handler_valid_o = 1'b0;
            ST_DISPATCH: handler_valid_o = 1'b1;
            default:     handler_valid_o = 1'b0;
        endcase
        msr_o          = msr_q;
        srr0_o         = srr0_q;
        srr1_o         = srr1_q;
        handler_addr_o = haddr_q;
    end

    p_srr0_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> srr0_o == $past(ret_addr_i));

    p_srr1_form_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (srr1_o[31:16] == 16'h0) && (srr1_o[15:0] == $past(msr_o[15:0])));

    p_clear_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> (msr_o & MSR_CLEAR_MASK) == '0);

    p_le_from_ile_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> msr_o[vidx(A_LE)] == $past(msr_o[vidx(A_ILE)]));

    p_base_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> handler_addr_o[31:20] ==
                   ($past(msr_o[vidx(A_IP)]) ? HIGH_BASE[31:20] : 12'h000));

    p_valid_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> handler_valid_o);

    p_valid_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> !handler_valid_o);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_i && !msr_we_i) |=> $stable(msr_o) && $stable(srr0_o) && $stable(srr1_o));

    p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_we_i && !take_i) |=> msr_o == $past(msr_wdata_i));

endmodule

// File: tb/exc_entry_save_bench.sv
`timescale 1ns/1ps
module exc_entry_save_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        take_i;
    logic [1:0]  vec_code_i;
    logic [31:0] ret_addr_i;
    logic        msr_we_i;
    logic [31:0] msr_wdata_i;
    logic [31:0] msr_o, srr0_o, srr1_o, handler_addr_o;
    logic        handler_valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    exc_entry_save u_exc_entry_save (
        .clk             (clk),
        .rst_n           (rst_n),
        .take_i          (take_i),
        .vec_code_i      (vec_code_i),
        .ret_addr_i      (ret_addr_i),
        .msr_we_i        (msr_we_i),
        .msr_wdata_i     (msr_wdata_i),
        .msr_o           (msr_o),
        .srr0_o          (srr0_o),
        .srr1_o          (srr1_o),
        .handler_addr_o  (handler_addr_o),
        .handler_valid_o (handler_valid_o)
    );

    function automatic int bi(input int n);
        return 31 - n;
    endfunction

    function automatic logic [31:0] exp_msr(input logic [31:0] m);
        logic [31:0] r;
        int clr [12] = '{13, 14, 16, 17, 18, 20, 21, 22, 23, 26, 27, 30};
        r = m;
        foreach (clr[k]) r[bi(clr[k])] = 1'b0;
        r[bi(31)] = m[bi(15)];
        return r;
    endfunction

    function automatic logic [31:0] exp_haddr(input logic [31:0] m, input logic [1:0] c);
        logic [31:0] off;
        off = (c == 2'd0) ? 32'h0000_0300 : 32'h0000_1100 + 32'(c) * 32'h100;
        return (m[bi(25)] ? 32'hFFF0_0000 : 32'h0) + off;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [31:0] v);
        @(negedge clk);
        msr_we_i = 1'b1; msr_wdata_i = v;
        @(negedge clk);
        msr_we_i = 1'b0;
        check("R10 sw write", msr_o, v);
    endtask

    task automatic entry(input logic [31:0] m, input logic [1:0] c, input logic [31:0] ra);
        sw_write(m);
        take_i = 1'b1; vec_code_i = c; ret_addr_i = ra;
        @(negedge clk);
        take_i = 1'b0;
        check("R2 srr0", srr0_o, ra);
        check("R3 srr1", srr1_o, {16'h0, m[15:0]});
        check("R4/R5 msr rewrite", msr_o, exp_msr(m));
        check("R6/R7 handler addr", handler_addr_o, exp_haddr(m, c));
        check("R8 valid high", 32'(handler_valid_o), 32'd1);
        @(negedge clk);
        check("R8 valid low", 32'(handler_valid_o), 32'd0);
        check("R9 msr hold", msr_o, exp_msr(m));
        check("R9 srr0 hold", srr0_o, ra);
        check("R9 srr1 hold", srr1_o, {16'h0, m[15:0]});
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] pats [8];
        logic [31:0] lf;
        rst_n = 1'b0; take_i = 1'b0; vec_code_i = 2'd0; ret_addr_i = '0;
        msr_we_i = 1'b0; msr_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 msr reset", msr_o, 32'h0);
        check("R1 srr0 reset", srr0_o, 32'h0);
        check("R1 srr1 reset", srr1_o, 32'h0);
        check("R1 haddr reset", handler_addr_o, 32'h0);
        check("R1 valid reset", 32'(handler_valid_o), 32'd0);

        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'h0001_0040; // interrupt-endian and prefix set
        pats[3] = 32'h0000_0040; // prefix only
        pats[4] = 32'h0001_0000; // interrupt-endian only
        lf = 32'hACE1_1234;
        for (int i = 5; i < 8; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            pats[i] = lf ^ 32'h5A5A_0F0F;
        end

        for (int p = 0; p < 8; p++)
            for (int c = 0; c < 4; c++)
                entry(pats[p], 2'(c), 32'h1000_0000 + 32'(p * 16 + c) * 4);

        // R10: take wins over simultaneous software write
        sw_write(32'h0001_1840);
        @(negedge clk);
        take_i = 1'b1; vec_code_i = 2'd3; ret_addr_i = 32'hCAFE_0004;
        msr_we_i = 1'b1; msr_wdata_i = 32'h1234_5678;
        @(negedge clk);
        take_i = 1'b0; msr_we_i = 1'b0;
        check("R10 take over write", msr_o, exp_msr(32'h0001_1840));
        check("R7 smi vector high base", handler_addr_o, 32'hFFF0_1400);

        // R8: back-to-back entries keep valid high
        sw_write(32'h0000_0000);
        take_i = 1'b1; vec_code_i = 2'd1; ret_addr_i = 32'h0000_0100;
        @(negedge clk);
        vec_code_i = 2'd2; ret_addr_i = 32'h0000_0200;
        check("R8 valid first", 32'(handler_valid_o), 32'd1);
        check("R7 dtlb store vector", handler_addr_o, 32'h0000_1200);
        @(negedge clk);
        take_i = 1'b0;
        check("R8 valid second", 32'(handler_valid_o), 32'd1);
        check("R7 breakpoint vector", handler_addr_o, 32'h0000_1300);
        check("R2 second srr0", srr0_o, 32'h0000_0200);
        @(negedge clk);
        check("R8 valid drop", 32'(handler_valid_o), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule